// File: doc/BRIEF.md
# Reference input selector with holdover tracking

This block decides which of several reference clock inputs feeds a phase-locked loop, and it follows the loop through its operating modes. Each input carries a loss-of-signal flag, an out-of-frequency flag and a mask bit. When the mask bit is set, the frequency flag is ignored. Each input also has a priority number. A switch-mode value picks the selection policy: manual, automatic non-revertive or automatic revertive.

The mode tracker reports one of four modes: free-run, lock acquisition, locked or holdover. It falls back to holdover or to free-run when no usable input is left, or when holdover is forced. Which of the two it falls back to depends on the holdover enable and on whether averaged frequency history exists. It moves from acquisition to locked only on an external lock indication.

The outputs are all registered. They reflect the inputs sampled at the previous rising clock edge.

Top module: `ref_select_top`

## Requirements
- R1: While reset is asserted, and after it is released until the next clock edge, active_o is 0, mode_o is 0 (free-run) and hold_stat_o is 1.
- R2: mode_o encodes 0 = free-run, 1 = lock acquisition, 2 = locked, 3 = holdover. hold_stat_o is 1 exactly when mode_o is 0 or 3. active_o holds the index 0..3 of the selected input.
- R3: Input i is valid when los_i[i] is 0 and either oof_i[i] is 0 or oof_mask_i[i] is 1 (a mask bit of 1 ignores out-of-frequency).
- R4: When sw_mode_i is 0 or 3 (manual), active_o takes man_sel_i at the next edge regardless of priority. The selected input is usable when it is valid.
- R5: In automatic modes (sw_mode_i 1 or 2), an input is eligible when it is valid and its 4-bit priority field prio_i[4i+3:4i] is nonzero. The smallest nonzero priority wins, and equal priorities go to the lowest index.
- R6: With sw_mode_i = 1 (non-revertive), active_o stays unchanged while the current input is eligible. It moves to the R5 winner only when the current input is not eligible.
- R7: With sw_mode_i = 2 (revertive), active_o moves to the R5 winner whenever any input is eligible.
- R8: When no usable input remains, a mode of acquisition or locked becomes holdover (3) if hold_en_i and hist_valid_i are both 1, and free-run (0) otherwise. In this case active_o keeps its last value.
- R9: force_hold_i = 1 drives the mode to the R8 fallback at the next edge, whatever the input state.
- R10: With a usable input and no force, free-run or holdover moves to acquisition. Acquisition moves to locked only when lock_i is 1. Locked returns to acquisition when lock_i is 0 or when active_o changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| los_i | input | 4 | Per-input loss of signal |
| oof_i | input | 4 | Per-input out of frequency |
| oof_mask_i | input | 4 | Per-input out-of-frequency ignore |
| prio_i | input | 16 | Per-input priority, 4 bits each, input 0 in the low bits |
| sw_mode_i | input | 2 | Selection policy |
| man_sel_i | input | 2 | Manual input index |
| force_hold_i | input | 1 | Force fallback mode |
| hold_en_i | input | 1 | Holdover enable |
| hist_valid_i | input | 1 | Frequency history exists |
| lock_i | input | 1 | External lock indication |
| active_o | output | 2 | Selected input index |
| mode_o | output | 2 | Operating mode |
| hold_stat_o | output | 1 | High in free-run or holdover |

## Verification
The bench builds the block with its defaults: four inputs and 4-bit priorities. With these settings every index code, the excluded priority 0 and priority ties can all be reached. A single running sequence of vectors walks the mode tracker through every transition. Along the way it moves between the manual, non-revertive and revertive policies, and it switches the mask, the history flag and the enable, so that both fallback targets are exercised. Directed steps then cover the reset state, including an asynchronous reset in the middle of a run.

// File: rtl/ref_sel_pkg.sv
package ref_sel_pkg;
  typedef enum logic [1:0] {
    MODE_FREE = 2'd0,
    MODE_ACQ  = 2'd1,
    MODE_LOCK = 2'd2,
    MODE_HOLD = 2'd3
  } mode_e;

  localparam logic [1:0] SW_MANUAL = 2'd0;
  localparam logic [1:0] SW_NONREV = 2'd1;
  localparam logic [1:0] SW_REV    = 2'd2;
endpackage

// File: rtl/ref_qualify.sv
module ref_qualify #(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 4
) (
  input  logic [N_IN-1:0]        los_i,
  input  logic [N_IN-1:0]        oof_i,
  input  logic [N_IN-1:0]        oof_mask_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  output logic [N_IN-1:0]        valid_o,
  output logic [N_IN-1:0]        elig_o
);
  for (genvar g = 0; g < N_IN; g++) begin : g_in
    assign valid_o[g] = ~los_i[g] & (~oof_i[g] | oof_mask_i[g]);
    assign elig_o[g]  = valid_o[g] & (prio_i[g*PRIO_W +: PRIO_W] != '0);
  end
endmodule

// File: rtl/ref_prio_pick.sv
module ref_prio_pick #(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic [N_IN-1:0]        elig_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  output logic [IDX_W-1:0]       best_o,
  output logic                   any_o
);
  logic [PRIO_W-1:0] best_p;

  // strict compare keeps the lowest index on ties
  always_comb begin
    best_o = '0;
    best_p = '1;
    any_o  = 1'b0;
    for (int i = 0; i < N_IN; i++) begin
      if (elig_i[i] && (!any_o || prio_i[i*PRIO_W +: PRIO_W] < best_p)) begin
        best_o = IDX_W'(i);
        best_p = prio_i[i*PRIO_W +: PRIO_W];
        any_o  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/ref_mode_fsm.sv
module ref_mode_fsm
  import ref_sel_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  avail_i,
  input  logic  switch_i,
  input  logic  force_hold_i,
  input  logic  hold_en_i,
  input  logic  hist_valid_i,
  input  logic  lock_i,
  output mode_e mode_o
);
  mode_e mode_q, mode_d, fallback;

  always_comb begin
    fallback = (hold_en_i && hist_valid_i) ? MODE_HOLD : MODE_FREE;
    mode_d   = mode_q;
    if (force_hold_i) begin
      mode_d = fallback;
    end else if (!avail_i) begin
      if (mode_q == MODE_ACQ || mode_q == MODE_LOCK) mode_d = fallback;
    end else if (switch_i) begin
      mode_d = MODE_ACQ;
    end else begin
      unique case (mode_q)
        MODE_FREE, MODE_HOLD: mode_d = MODE_ACQ;
        MODE_ACQ:             mode_d = lock_i ? MODE_LOCK : MODE_ACQ;
        MODE_LOCK:            mode_d = lock_i ? MODE_LOCK : MODE_ACQ;
        default:              mode_d = MODE_FREE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_FREE;
    else         mode_q <= mode_d;
  end

  assign mode_o = mode_q;
endmodule

// File: rtl/ref_select_top.sv
module ref_select_top
  import ref_sel_pkg::*;
#(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N_IN)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_IN-1:0]        los_i,
  input  logic [N_IN-1:0]        oof_i,
  input  logic [N_IN-1:0]        oof_mask_i,
  input  logic [N_IN*PRIO_W-1:0] prio_i,
  input  logic [1:0]             sw_mode_i,
  input  logic [IDX_W-1:0]       man_sel_i,
  input  logic                   force_hold_i,
  input  logic                   hold_en_i,
  input  logic                   hist_valid_i,
  input  logic                   lock_i,
  output logic [IDX_W-1:0]       active_o,
  output logic [1:0]             mode_o,
  output logic                   hold_stat_o
);
  logic [N_IN-1:0]  valid, elig;
  logic [IDX_W-1:0] best, act_q, act_d;
  logic             any_elig, manual, avail;
  mode_e            mode;

  ref_qualify #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_qual (
    .los_i(los_i), .oof_i(oof_i), .oof_mask_i(oof_mask_i), .prio_i(prio_i),
    .valid_o(valid), .elig_o(elig)
  );

  ref_prio_pick #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_pick (
    .elig_i(elig), .prio_i(prio_i), .best_o(best), .any_o(any_elig)
  );

  assign manual = (sw_mode_i != SW_NONREV) && (sw_mode_i != SW_REV);

  always_comb begin
    act_d = act_q;
    if (manual) begin
      act_d = man_sel_i;
      avail = valid[man_sel_i];
    end else begin
      avail = any_elig;
      if (any_elig && !(sw_mode_i == SW_NONREV && elig[act_q])) act_d = best;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= '0;
    else         act_q <= act_d;
  end

  ref_mode_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .avail_i(avail), .switch_i(act_d != act_q),
    .force_hold_i(force_hold_i), .hold_en_i(hold_en_i),
    .hist_valid_i(hist_valid_i), .lock_i(lock_i), .mode_o(mode)
  );

  assign active_o    = act_q;
  assign mode_o      = mode;
  assign hold_stat_o = (mode == MODE_FREE) || (mode == MODE_HOLD);
endmodule

// File: rtl/ref_sel_chk.sv
module ref_sel_chk #(
  parameter int N_IN   = 4,
  parameter int PRIO_W = 4,
  localparam int IDX_W = $clog2(N_IN)
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [N_IN-1:0]        los_i,
  input logic [N_IN-1:0]        oof_i,
  input logic [N_IN-1:0]        oof_mask_i,
  input logic [N_IN*PRIO_W-1:0] prio_i,
  input logic [1:0]             sw_mode_i,
  input logic                   force_hold_i,
  input logic                   hold_en_i,
  input logic                   hist_valid_i,
  input logic                   lock_i,
  input logic [IDX_W-1:0]       active_o,
  input logic [1:0]             mode_o
);
  logic cur_elig;
  always_comb begin
    cur_elig = 1'b0;
    for (int i = 0; i < N_IN; i++)
      if (IDX_W'(i) == active_o)
        cur_elig = !los_i[i] && (!oof_i[i] || oof_mask_i[i]) &&
                   (prio_i[i*PRIO_W +: PRIO_W] != '0);
  end

  // R6
  nonrev_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_mode_i == 2'd1 && cur_elig) |=> $stable(active_o));

  // R9
  force_fallback_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    force_hold_i |=> (mode_o == 2'd0 || mode_o == 2'd3));

  // R8
  no_history_free_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_hold_i && !hist_valid_i) |=> mode_o == 2'd0);

  // R10
  lock_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd1 && !lock_i) |=> mode_o != 2'd2);

  // R10
  switch_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_o == 2'd2) |=> (mode_o != 2'd2 || $stable(active_o)));

  // R8
  disabled_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_hold_i && !hold_en_i) |=> mode_o == 2'd0);
endmodule

bind ref_select_top ref_sel_chk #(.N_IN(N_IN), .PRIO_W(PRIO_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .los_i(los_i), .oof_i(oof_i),
  .oof_mask_i(oof_mask_i), .prio_i(prio_i), .sw_mode_i(sw_mode_i),
  .force_hold_i(force_hold_i), .hold_en_i(hold_en_i),
  .hist_valid_i(hist_valid_i), .lock_i(lock_i), .active_o(active_o),
  .mode_o(mode_o)
);

// File: tb/sim_ref_select_top.sv
module sim_ref_select_top;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 25;

  typedef struct packed {
    logic [15:0] prio;
    logic [3:0]  los, oof, msk;
    logic [1:0]  swm, man;
    logic        frc, hen, hv, lk;
    logic [1:0]  eact, emode;
    logic [3:0]  req;
  } vec_t;

  // running sequence; each row is checked one edge after it is applied
  localparam vec_t VEC [NV] = '{
    '{16'h0213, 4'hF, 4'h0, 4'h0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd0, 4'd8},  // R8 nothing usable
    '{16'h0213, 4'hE, 4'h0, 4'h0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b0, 2'd0, 2'd1, 4'd10}, // R10 free->acq
    '{16'h0213, 4'hE, 4'h0, 4'h0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd2, 4'd10}, // R10 acq->lock
    '{16'h0213, 4'hC, 4'h0, 4'h0, 2'd1, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd2, 4'd6},  // R6 stays
    '{16'h0213, 4'hC, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 2'd1, 4'd7},  // R7 reverts
    '{16'h0213, 4'hC, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 2'd2, 4'd10},
    '{16'h0213, 4'hC, 4'h2, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd0, 2'd1, 4'd3},  // R3 oof counts
    '{16'h0213, 4'hC, 4'h2, 4'h2, 2'd2, 2'd0, 1'b0, 1'b1, 1'b0, 1'b1, 2'd1, 2'd1, 4'd3},  // R3 oof masked
    '{16'h0213, 4'hF, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 2'd3, 4'd8},  // R8 holdover
    '{16'h0213, 4'hF, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd3, 4'd8},
    '{16'h0213, 4'hB, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd1, 4'd10}, // R10 hold->acq
    '{16'h0213, 4'hB, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 4'd10},
    '{16'h0213, 4'hB, 4'h0, 4'h0, 2'd2, 2'd0, 1'b1, 1'b1, 1'b1, 1'b1, 2'd2, 2'd3, 4'd9},  // R9 forced
    '{16'h0213, 4'hB, 4'h0, 4'h0, 2'd2, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1, 2'd2, 2'd0, 4'd9},  // R9 no history
    '{16'h0213, 4'hB, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd2, 2'd1, 4'd10},
    '{16'h0213, 4'hB, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 2'd2, 4'd10},
    '{16'h0213, 4'hF, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1, 1'b1, 2'd2, 2'd0, 4'd8},  // R8 disabled
    '{16'h0213, 4'h7, 4'h0, 4'h0, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b0, 2'd3, 2'd1, 4'd4},  // R4 prio ignored
    '{16'h0213, 4'h7, 4'h0, 4'h0, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 2'd2, 4'd10},
    '{16'h0213, 4'h7, 4'h8, 4'h0, 2'd0, 2'd3, 1'b0, 1'b1, 1'b1, 1'b1, 2'd3, 2'd3, 4'd8},  // R8 manual loss
    '{16'h0213, 4'h6, 4'h0, 4'h0, 2'd0, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd0, 2'd1, 4'd4},
    '{16'h0213, 4'h7, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd0, 2'd3, 4'd5},  // R5 prio 0 excluded
    '{16'h1111, 4'h9, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b0, 2'd1, 2'd1, 4'd5},  // R5 tie
    '{16'h1111, 4'h9, 4'h0, 4'h0, 2'd2, 2'd0, 1'b0, 1'b1, 1'b1, 1'b1, 2'd1, 2'd2, 4'd10},
    '{16'h1111, 4'h9, 4'h0, 4'h0, 2'd3, 2'd2, 1'b0, 1'b1, 1'b1, 1'b1, 2'd2, 2'd1, 4'd4}   // R4 code 3, R10 switch
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  los = 4'hF, oof = '0, msk = '0;
  logic [15:0] prio = 16'h0213;
  logic [1:0]  swm = '0, man = '0;
  logic        frc = 1'b0, hen = 1'b1, hv = 1'b0, lk = 1'b0;
  logic [1:0]  act, mode;
  logic        hstat;
  int          checks = 0, errors = 0;
  bit          done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ref_select_top u0 (
    .clk_i(clk), .rst_ni(rst_n), .los_i(los), .oof_i(oof), .oof_mask_i(msk),
    .prio_i(prio), .sw_mode_i(swm), .man_sel_i(man), .force_hold_i(frc),
    .hold_en_i(hen), .hist_valid_i(hv), .lock_i(lk),
    .active_o(act), .mode_o(mode), .hold_stat_o(hstat)
  );

  task automatic check(input string tag, input logic [1:0] ea, input logic [1:0] em);
    logic eh;
    eh = (em == 2'd0) || (em == 2'd3);
    checks++;
    if (act !== ea || mode !== em || hstat !== eh) begin
      errors++;
      $display("FAIL %s active=%0d mode=%0d hold=%0d expected active=%0d mode=%0d hold=%0d",
               tag, act, mode, hstat, ea, em, eh);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 2000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", 2'd0, 2'd0);
    rst_n = 1'b1;
    #1 check("R1 after release", 2'd0, 2'd0);

    for (int v = 0; v < NV; v++) begin
      @(negedge clk);
      prio = VEC[v].prio; los = VEC[v].los; oof = VEC[v].oof; msk = VEC[v].msk;
      swm = VEC[v].swm; man = VEC[v].man; frc = VEC[v].frc; hen = VEC[v].hen;
      hv = VEC[v].hv; lk = VEC[v].lk;
      @(posedge clk);
      #1 check($sformatf("R%0d R2 vector %0d", VEC[v].req, v), VEC[v].eact, VEC[v].emode);
    end

    // R1 asynchronous reset mid-run, then outputs hold until the next edge
    @(negedge clk);
    #2 rst_n = 1'b0;
    #1 check("R1 async reset", 2'd0, 2'd0);
    @(negedge clk);
    rst_n = 1'b1;
    #1 check("R1 released", 2'd0, 2'd0);

    // R10 locked drops to acquisition when lock_i falls
    @(negedge clk); swm = 2'd0; man = 2'd1; los = 4'h0; frc = 1'b0; lk = 1'b1;
    @(posedge clk); #1 check("R10 acquire", 2'd1, 2'd1);
    @(posedge clk); #1 check("R10 locked", 2'd1, 2'd2);
    @(negedge clk); lk = 1'b0;
    @(posedge clk); #1 check("R10 lock lost", 2'd1, 2'd1);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule